// File: doc/BRIEF.md
# Zero-Substitution Line Decoder (HDB3 / B8ZS / AMI)

This block sits behind a dual-rail line receiver and turns positive and negative pulse marks into plain NRZ data. The receiver supplies one symbol per bit period, qualified by a bit-enable strobe. Clock recovery and slicing happen upstream. In plain alternate-mark mode every mark is a one. In substitution mode the block also undoes the zero-run replacement codes: the four-zero code for E1 lines and the eight-zero code for T1 lines.

Bipolar violations are found by remembering the polarity of the last single-rail mark. Each incoming symbol is classified as it arrives and then held in a short delay window. When the last symbol of a valid substitution pattern enters the window, the marks inside that pattern are rewritten to zeros before they reach the output. A violation that never becomes part of a valid pattern leaves the block as a one, with the code-violation flag raised. A mark present on both rails at once is treated the same way.

Top module: `zsub_line_decoder`

## Requirements
- R1: A synchronous active-low reset drives `dout` and `code_err` to 0, fills the delay window with zeros and forgets the last-mark polarity. The first mark after reset is therefore never treated as a violation.
- R2: The latency is fixed at DEPTH = 8 bit periods in every mode. The outputs change only on the clock edge that samples `bit_en` high. With `bit_en` low, the outputs hold and rail activity is ignored. For the first DEPTH bit periods after reset, the outputs are 0.
- R3: With `sub_en` = 0 (alternate-mark mode), a mark on either rail decodes as 1 and a space decodes as 0. No pattern is removed, and `code_err` is raised only for a mark on both rails.
- R4: With `sub_en` = 1 and `std_t1` = 0, the line sequence space, space, space, violation decodes as four zeros.
- R5: With `sub_en` = 1 and `std_t1` = 0, the sequence balancing mark, space, space, violation decodes as four zeros. Both the balancing mark and the violation are removed. Successive substitutions alternate in polarity.
- R6: With `sub_en` = 1 and `std_t1` = 1, the sequence 0,0,0,V,B,0,V,B (V = violation, B = normal-polarity mark) decodes as eight zeros.
- R7: A violation is a single-rail mark whose polarity equals that of the previous single-rail mark. Polarity is tracked across every mark, including removed ones.
- R8: In substitution mode, a violation that does not complete a valid pattern for the selected standard is output as 1 with `code_err` = 1. This includes the four-zero pattern received in T1 mode.
- R9: A mark on both rails is output as 1 with `code_err` = 1, and it leaves the tracked polarity unchanged.
- R10: Whenever `code_err` is 1, `dout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | High for one cycle per received bit period |
| rx_pos | input | 1 | Positive-rail mark |
| rx_neg | input | 1 | Negative-rail mark |
| sub_en | input | 1 | 1 = zero-substitution decoding, 0 = alternate-mark only |
| std_t1 | input | 1 | 1 = eight-zero T1 code, 0 = four-zero E1 code |
| dout | output | 1 | Decoded NRZ bit, DEPTH bit periods late |
| code_err | output | 1 | Code-violation flag aligned with `dout` |

## Verification
Assertions check the following on every cycle:
- Reset clearing of the outputs.
- Holding of the outputs while `bit_en` is low.
- The rule that a flagged bit is always a one.
- The polarity register following each single-rail mark and ignoring double-rail marks.
- Both violations of an eight-zero pattern still being open when that pattern completes.

Only the bench scenarios can show that whole streams come out intact after fixed latency. These streams are encoded with both substitution codes and with plain alternate marks. The scenarios also cover the handling of stray and misplaced violations, the cross-standard pattern and forgetting polarity across reset.

// File: rtl/zsd_pkg.sv
// Package: shared symbol record for the zero-substitution decoder.
// Assumes: one record per received bit period.
package zsd_pkg;

    // Smallest window that still holds a full eight-zero pattern.
    localparam int MIN_DEPTH = 8;

    // Classified line symbol as stored in the delay window.
    typedef struct packed {
        logic pulse;  // mark on either rail
        logic neg;    // polarity of a single-rail mark (1 = negative)
        logic dbl;    // marks on both rails at once
        logic viol;   // single-rail mark repeating the last polarity
        logic data;   // provisional decoded bit
        logic unres;  // violation not yet explained by a pattern
    } zs_sym_t;

endpackage

// File: rtl/zs_classify.sv
// Module: zs_classify
// Classifies each incoming rail pair into a symbol record and tracks the
// polarity of the last single-rail mark.
// Assumes: rails are sampled only when bit_en is high; double-rail marks
// leave the polarity history untouched.
module zs_classify
    import zsd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_en,
    input  logic    rx_pos,
    input  logic    rx_neg,
    input  logic    sub_en,
    output zs_sym_t sym
);

    logic last_neg_q;
    logic seen_q;
    logic single;

    // Build the symbol record from the rails and the polarity history.
    always_comb begin
        single     = rx_pos ^ rx_neg;
        sym        = '0;
        sym.pulse  = rx_pos | rx_neg;
        sym.dbl    = rx_pos & rx_neg;
        sym.neg    = rx_neg & ~rx_pos;
        sym.viol   = sub_en & single & seen_q & (rx_neg == last_neg_q);
        sym.data   = rx_pos | rx_neg;
        sym.unres  = sym.viol;
    end

    // Remember the polarity of the latest single-rail mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_neg_q <= 1'b0;
            seen_q     <= 1'b0;
        end else if (bit_en && single) begin
            last_neg_q <= rx_neg;
            seen_q     <= 1'b1;
        end
    end

    // R7: the history follows every single-rail mark.
    a_r7_pol_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (rx_pos != rx_neg)) |=> (seen_q && (last_neg_q == $past(rx_neg))));

    // R9: a double-rail mark leaves the history untouched.
    a_r9_dbl_keeps_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && rx_pos && rx_neg) |=> ($stable(last_neg_q) && $stable(seen_q)));

endmodule

// File: rtl/zs_window.sv
// Module: zs_window
// Delay window of classified symbols. When the closing symbol of a valid
// substitution pattern arrives, the marks belonging to that pattern are
// rewritten to zeros before they leave the window.
// Assumes: DEPTH >= MIN_DEPTH so an eight-zero pattern fits inside.
module zs_window
    import zsd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_en,
    input  logic    std_t1,
    input  zs_sym_t in_sym,
    output logic    tail_data,
    output logic    tail_cv
);

    localparam int LAST = DEPTH - 1;

    zs_sym_t win [DEPTH];
    zs_sym_t nxt [DEPTH];
    logic    hdb_hit;
    logic    b8_hit;

    // A plain mark of normal polarity, eligible as a balancing mark.
    function automatic logic is_bal(input zs_sym_t s);
        return s.pulse && !s.dbl && !s.viol;
    endfunction

    // Four-zero pattern closes on a violation after two spaces.
    always_comb begin
        hdb_hit = !std_t1 && in_sym.viol && !win[0].pulse && !win[1].pulse &&
                  (!win[2].pulse || is_bal(win[2]));
    end

    // Eight-zero pattern closes on its second balancing mark.
    always_comb begin
        b8_hit = std_t1 && is_bal(in_sym) && win[0].viol && !win[1].pulse &&
                 is_bal(win[2]) && win[3].viol && !win[4].pulse &&
                 !win[5].pulse && !win[6].pulse;
    end

    // Next window contents: shift, then strip any completed pattern.
    always_comb begin
        nxt[0] = in_sym;
        for (int i = 1; i < DEPTH; i++) begin
            nxt[i] = win[i-1];
        end
        if (hdb_hit) begin
            nxt[0].data  = 1'b0;
            nxt[0].unres = 1'b0;
            nxt[3].data  = 1'b0;
        end
        if (b8_hit) begin
            nxt[0].data  = 1'b0;
            nxt[0].unres = 1'b0;
            nxt[1].data  = 1'b0;
            nxt[1].unres = 1'b0;
            nxt[3].data  = 1'b0;
            nxt[3].unres = 1'b0;
            nxt[4].data  = 1'b0;
            nxt[4].unres = 1'b0;
        end
    end

    // One register stage per window slot, advanced once per bit period.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win[g] <= '0;
            end else if (bit_en) begin
                win[g] <= nxt[g];
            end
        end
    end

    assign tail_data = win[LAST].data;
    assign tail_cv   = win[LAST].dbl | win[LAST].unres;

    // R6: both violations of an eight-zero pattern are still open when it closes.
    a_r6_b8_open_viol: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && b8_hit) |-> (win[3].unres && win[0].unres));

endmodule

// File: rtl/zs_emit.sv
// Module: zs_emit
// Output register: takes the oldest window slot once per bit period.
// Assumes: tail inputs are stable between bit-enable strobes.
module zs_emit (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic tail_data,
    input  logic tail_cv,
    output logic dout,
    output logic code_err
);

    // Register the released bit and its violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= 1'b0;
            code_err <= 1'b0;
        end else if (bit_en) begin
            dout     <= tail_data;
            code_err <= tail_cv;
        end
    end

    // R1: reset clears both outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!dout && !code_err));

    // R2: outputs hold while no bit is strobed.
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(dout) && $stable(code_err)));

    // R10: a flagged bit is always a one.
    a_r10_flag_is_one: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> dout);

endmodule

// File: rtl/zsub_line_decoder.sv
// Module: zsub_line_decoder
// Top level: dual-rail to NRZ decoder with removal of four-zero (E1) and
// eight-zero (T1) substitution codes and code-violation flagging.
// Assumes: one symbol per bit_en strobe; mode inputs change only around reset.
module zsub_line_decoder #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic sub_en,
    input  logic std_t1,
    output logic dout,
    output logic code_err
);

    zsd_pkg::zs_sym_t sym;
    logic             tail_data;
    logic             tail_cv;

    zs_classify u_cls (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .rx_pos (rx_pos),
        .rx_neg (rx_neg),
        .sub_en (sub_en),
        .sym    (sym)
    );

    zs_window #(.DEPTH(DEPTH)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .std_t1    (std_t1),
        .in_sym    (sym),
        .tail_data (tail_data),
        .tail_cv   (tail_cv)
    );

    zs_emit u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .tail_data (tail_data),
        .tail_cv   (tail_cv),
        .dout      (dout),
        .code_err  (code_err)
    );

endmodule

// File: tb/zsub_line_decoder_tb.sv
`timescale 1ns/1ps
module zsub_line_decoder_tb;

    localparam int DEPTH = 8;

    typedef struct {
        logic  d;
        logic  c;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic sub_en = 1'b0;
    logic std_t1 = 1'b0;
    logic dout;
    logic code_err;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic en_seen = 1'b0;
    bit   done = 1'b0;
    bit   enc_neg = 1'b1;
    int   enc_cnt = 0;

    always #2.5 clk = ~clk;

    zsub_line_decoder #(.DEPTH(DEPTH)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_pos   (rx_pos),
        .rx_neg   (rx_neg),
        .sub_en   (sub_en),
        .std_t1   (std_t1),
        .dout     (dout),
        .code_err (code_err)
    );

    // Monitor: one expected item per strobed edge, compared at the falling edge.
    always @(posedge clk) en_seen <= bit_en && rst_n;

    always @(negedge clk) begin
        if (en_seen) begin
            exp_t e;
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: output with empty scoreboard, dout=%b expected none", dout);
            end else begin
                e = q.pop_front();
                if (dout !== e.d || code_err !== e.c) begin
                    n_fail++;
                    $display("FAIL %s: dout=%b code_err=%b expected dout=%b code_err=%b",
                             e.req, dout, code_err, e.d, e.c);
                end
            end
        end
    end

    task automatic send(input bit p, input bit n, input bit d, input bit c, input string req);
        @(negedge clk);
        rx_pos = p;
        rx_neg = n;
        bit_en = 1'b1;
        q.push_back('{d, c, req});
    endtask

    task automatic emit_pulse(input bit neg, input bit d, input string req);
        send(!neg, neg, d, 1'b0, req);
        enc_neg = neg;
    endtask

    // R2: idle cycles with a stray mark on the rail; outputs must hold.
    task automatic gap(input int k);
        logic rd, rc;
        @(negedge clk);
        bit_en = 1'b0;
        rx_pos = 1'b1;
        rx_neg = 1'b0;
        @(negedge clk);
        rd = dout;
        rc = code_err;
        repeat (k) begin
            @(negedge clk);
            n_chk++;
            if (dout !== rd || code_err !== rc) begin
                n_fail++;
                $display("FAIL R2: idle change dout=%b code_err=%b expected dout=%b code_err=%b",
                         dout, code_err, rd, rc);
            end
        end
    endtask

    task automatic do_reset(input bit sub, input bit t1);
        @(negedge clk);
        bit_en = 1'b0;
        rx_pos = 1'b0;
        rx_neg = 1'b0;
        @(negedge clk);
        rst_n  = 1'b0;
        sub_en = sub;
        std_t1 = t1;
        repeat (2) @(negedge clk);
        n_chk++;
        if (dout !== 1'b0 || code_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: after reset dout=%b code_err=%b expected dout=0 code_err=0",
                     dout, code_err);
        end
        q.delete();
        for (int i = 0; i < DEPTH; i++) q.push_back('{1'b0, 1'b0, "R2"});
        rst_n   = 1'b1;
        enc_neg = 1'b1;
        enc_cnt = 0;
    endtask

    task automatic flush();
        for (int i = 0; i < DEPTH; i++) send(1'b0, 1'b0, 1'b0, 1'b0, "R2");
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    function automatic bit zrun(input bit d[], input int k, input int len);
        for (int j = 0; j < len; j++) if (d[k+j]) return 1'b0;
        return 1'b1;
    endfunction

    // Driver: builds a data stream, line-codes it, and queues the original bits.
    task automatic enc_stream(input bit sub, input bit t1, input int nbits);
        bit d[];
        int i;
        int k;
        bit L;
        string tag;
        d = new[nbits];
        i = 0;
        while (i < nbits) begin
            if ($urandom_range(0, 3) == 0) begin
                int len = $urandom_range(3, 12);
                for (int j = 0; j < len && i < nbits; j++) begin
                    d[i] = 1'b0;
                    i++;
                end
            end else begin
                d[i] = $urandom_range(0, 1);
                i++;
            end
        end
        d[0] = 1'b1;
        tag = sub ? "R7" : "R3";
        k = 0;
        while (k < nbits) begin
            if (sub && !t1 && k + 3 < nbits && zrun(d, k, 4)) begin
                if (enc_cnt % 2 == 1) begin
                    repeat (3) send(1'b0, 1'b0, 1'b0, 1'b0, "R4");
                    emit_pulse(enc_neg, 1'b0, "R4");
                end else begin
                    emit_pulse(!enc_neg, 1'b0, "R5");
                    repeat (2) send(1'b0, 1'b0, 1'b0, 1'b0, "R5");
                    emit_pulse(enc_neg, 1'b0, "R5");
                end
                enc_cnt = 0;
                k += 4;
            end else if (sub && t1 && k + 7 < nbits && zrun(d, k, 8)) begin
                L = enc_neg;
                repeat (3) send(1'b0, 1'b0, 1'b0, 1'b0, "R6");
                emit_pulse(L, 1'b0, "R6");
                emit_pulse(!L, 1'b0, "R6");
                send(1'b0, 1'b0, 1'b0, 1'b0, "R6");
                emit_pulse(!L, 1'b0, "R6");
                emit_pulse(L, 1'b0, "R6");
                k += 8;
            end else if (d[k]) begin
                emit_pulse(!enc_neg, 1'b1, tag);
                enc_cnt++;
                k++;
            end else begin
                send(1'b0, 1'b0, 1'b0, 1'b0, tag);
                k++;
            end
            if ($urandom_range(0, 11) == 0) gap(2);
        end
    endtask

    initial begin
        // R1 reset state, then alternate-mark mode (R3, R9).
        do_reset(1'b0, 1'b0);
        enc_stream(1'b0, 1'b0, 60);
        send(1'b1, 1'b0, 1'b1, 1'b0, "R3");
        send(1'b1, 1'b0, 1'b1, 1'b0, "R3");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        send(1'b1, 1'b0, 1'b1, 1'b0, "R3");
        send(1'b1, 1'b1, 1'b1, 1'b1, "R9");
        flush();

        // Four-zero code streams (R4, R5, R7).
        do_reset(1'b1, 1'b0);
        enc_stream(1'b1, 1'b0, 240);
        flush();

        // Eight-zero code streams (R6, R7).
        do_reset(1'b1, 1'b1);
        enc_stream(1'b1, 1'b1, 240);
        flush();

        // Hand-built corner cases in four-zero mode.
        do_reset(1'b1, 1'b0);
        send(1'b0, 1'b1, 1'b1, 1'b0, "R1");
        do_reset(1'b1, 1'b0);
        send(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        send(1'b0, 1'b1, 1'b1, 1'b0, "R1");
        send(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        send(1'b1, 1'b0, 1'b1, 1'b1, "R8");
        send(1'b0, 1'b1, 1'b0, 1'b0, "R5");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        send(1'b0, 1'b1, 1'b0, 1'b0, "R5");
        send(1'b0, 1'b1, 1'b1, 1'b1, "R7");
        send(1'b1, 1'b1, 1'b1, 1'b1, "R9");
        send(1'b1, 1'b0, 1'b1, 1'b0, "R9");
        flush();

        // Four-zero pattern received in T1 mode (R8).
        do_reset(1'b1, 1'b1);
        send(1'b1, 1'b0, 1'b1, 1'b0, "R8");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        send(1'b1, 1'b0, 1'b1, 1'b1, "R8");
        flush();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R2: watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule